// File: doc/BRIEF.md
# Shared-Prescaler Multi-Channel Timer Unit

This block is the register front end of a timer peripheral with up to eight down-counting channels. A bus master reaches it through a 32-bit word interface made of an address, separate read and write strobes, write data and registered read data. One 16-bit prescaler, with its own reload register, produces the tick that every channel counts. A read-only capability word tells software how many channels exist, which interrupt number the first channel uses, and which optional features are present.

Each channel runs a two-state machine. It is in HALT after reset. The START transition goes to COUNT on a control write with the enable bit set. The STOP transition goes back to HALT on a control write with the enable bit clear. The EXPIRE transition goes back to HALT when the counter underflows and restart is off. While in COUNT, an underflow with restart on takes the RELOAD self-transition, which copies the channel's reload value into the counter. On every underflow with interrupt enable set, the channel latches a pending flag and gives a one-cycle pulse on its own interrupt output.

The address map uses 16-byte windows. Window 0 holds the unit registers at offsets 0x0 (prescaler value), 0x4 (prescaler reload) and 0x8 (capability). Channel n sits at 0x10*(n+1): counter at +0x0, reload at +0x4 and control at +0x8. Control bit positions are enable 0, restart 1, load 2, interrupt enable 3 and pending 4.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the prescaler value, the prescaler reload, and every channel's counter, reload and control word read as 0, and all interrupt outputs are low.
- R2: A read strobe returns the register selected by the address on rd_data after the next rising clock edge. Writes go to the register at the decoded offset: unit window at slot 0, channel n at slot n+1, with word 0 = counter, 1 = reload, 2 = control.
- R3: The prescaler value and prescaler reload registers store only bits 15:0 of the written data and read with bits 31:16 as zero.
- R4: The prescaler counts down by one per clock. When it is zero it asserts the tick for that cycle and loads the prescaler reload value, so ticks come every reload+1 clocks. A write to the prescaler value overrides the count.
- R5: The capability word at offset 0x08 reads as the channel count (modulo 8) in bits 2:0, the base interrupt number in bits 7:3, and 1 in bits 8 and 9 (0x342 with the defaults). Writes to it change nothing.
- R6: Only address bits 7:0 are decoded. Reads return 0 at word 3 of any window and in any window whose channel does not exist.
- R7: In COUNT, a channel decrements once per tick. The tick that finds the counter at 0 is an underflow, so underflow comes counter+1 ticks after the count starts. With interrupt enable set, the channel's interrupt output is high for exactly the one cycle after the underflow.
- R8: With restart set, an underflow reloads the counter from the channel reload value and counting continues, giving an interrupt period of (channel reload+1)*(prescaler reload+1) clocks.
- R9: With restart clear, an underflow moves the channel to HALT: the enable bit reads 0, the counter stays at 0, and no further interrupts follow.
- R10: A control write with load set copies the channel reload value into the counter. Load always reads as 0. The pending bit (bit 4) is set by an underflow with interrupt enable on, is cleared by a control write with bit 4 = 1, and is left unchanged by a control write with bit 4 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address of the word accessed |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | NCH | One interrupt pulse line per channel |

## Verification
The bench measures the spacing between interrupt pulses with a prescaler reload of 3 and a channel reload of 2. A design that counted down to zero instead of through the underflow, or that ticked every reload clocks, would show a period other than 12. A one-shot run checks that underflow lands exactly counter+1 ticks after the start and that the channel then halts with its counter at zero. A design that re-armed itself would raise a second pulse. The pending flag is written with bit 4 clear and then with bit 4 set, which exposes write-one-to-clear confused with plain storage. Writes to the capability word, the masking of the upper 16 bits of the prescaler registers, holes in the map and absent channels are each read back; a wrong decode returns stale or aliased data.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        CH_HALT  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_t;

    localparam int unsigned CTL_EN  = 0;
    localparam int unsigned CTL_RST = 1;
    localparam int unsigned CTL_LD  = 2;
    localparam int unsigned CTL_IE  = 3;
    localparam int unsigned CTL_PND = 4;

    // word index inside a 16-byte window
    localparam logic [1:0] WRD_CNT = 2'd0;
    localparam logic [1:0] WRD_RLD = 2'd1;
    localparam logic [1:0] WRD_CTL = 2'd2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_val,
    input  logic          wr_rld,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] val,
    output logic [PW-1:0] rld,
    output logic          tick
);
    assign tick = (val == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
            rld <= '0;
        end else begin
            if (wr_rld)
                rld <= wdata;
            if (wr_val)
                val <= wdata;
            else if (tick)
                val <= rld;
            else
                val <= val - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_cnt,
    input  logic          wr_rld,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] rld,
    output logic [DW-1:0] ctl,
    output logic          irq
);
    ch_state_t st, st_n;
    logic      restart, ie, pend;
    logic      uf;

    assign uf = (st == CH_COUNT) && tick && (cnt == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= CH_HALT;
        else
            st <= st_n;
    end

    // next state: START, STOP, EXPIRE
    always_comb begin
        st_n = st;
        unique case (st)
            CH_HALT: begin
                if (wr_ctl && wdata[CTL_EN])
                    st_n = CH_COUNT;
            end
            CH_COUNT: begin
                if (wr_ctl && !wdata[CTL_EN])
                    st_n = CH_HALT;
                else if (!wr_ctl && !wr_cnt && uf && !restart)
                    st_n = CH_HALT;
            end
            default: st_n = CH_HALT;
        endcase
    end

    // counter, settings and interrupt outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rld     <= '0;
            restart <= 1'b0;
            ie      <= 1'b0;
            pend    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (wr_rld)
                rld <= wdata[CW-1:0];
            if (wr_ctl) begin
                restart <= wdata[CTL_RST];
                ie      <= wdata[CTL_IE];
                if (wdata[CTL_LD])
                    cnt <= rld;
            end else if (wr_cnt) begin
                cnt <= wdata[CW-1:0];
            end else if (uf) begin
                if (restart)
                    cnt <= rld;
            end else if (st == CH_COUNT && tick) begin
                cnt <= cnt - 1'b1;
            end
            pend <= (wr_ctl && wdata[CTL_PND]) ? 1'b0 : (pend | (uf & ie));
            irq  <= uf & ie;
        end
    end

    assign ctl = DW'({pend, ie, 1'b0, restart, st == CH_COUNT});
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int IRQ_BASE = 8,
    parameter int CW       = 32,
    parameter int PW       = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [7:0]     addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rd_data,
    output logic [NCH-1:0] irq
);
    localparam int DW = 32;
    localparam logic [31:0] CFG_WORD = 32'(NCH % 8) | (32'(IRQ_BASE % 32) << 3) | 32'h300;

    logic [3:0] slot;
    logic [1:0] word;
    logic       unit_hit;
    assign slot     = addr[7:4];
    assign word     = addr[3:2];
    assign unit_hit = (slot == 4'd0);

    logic          psc_wr_val, psc_wr_rld, psc_tick;
    logic [PW-1:0] psc_val, psc_rld;
    assign psc_wr_val = wr_en && unit_hit && (word == WRD_CNT);
    assign psc_wr_rld = wr_en && unit_hit && (word == WRD_RLD);

    tmr_prescaler #(.PW(PW)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_val (psc_wr_val),
        .wr_rld (psc_wr_rld),
        .wdata  (wdata[PW-1:0]),
        .val    (psc_val),
        .rld    (psc_rld),
        .tick   (psc_tick)
    );

    logic [NCH-1:0]         ch_wr_cnt, ch_wr_rld, ch_wr_ctl;
    logic [NCH-1:0][CW-1:0] ch_cnt, ch_rld;
    logic [NCH-1:0][DW-1:0] ch_ctl;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_wr_cnt[i] = wr_en && (slot == 4'(i + 1)) && (word == WRD_CNT);
        assign ch_wr_rld[i] = wr_en && (slot == 4'(i + 1)) && (word == WRD_RLD);
        assign ch_wr_ctl[i] = wr_en && (slot == 4'(i + 1)) && (word == WRD_CTL);

        tmr_channel #(.CW(CW), .DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (psc_tick),
            .wr_cnt (ch_wr_cnt[i]),
            .wr_rld (ch_wr_rld[i]),
            .wr_ctl (ch_wr_ctl[i]),
            .wdata  (wdata),
            .cnt    (ch_cnt[i]),
            .rld    (ch_rld[i]),
            .ctl    (ch_ctl[i]),
            .irq    (irq[i])
        );
    end

    logic [31:0] rd_next;
    always_comb begin
        rd_next = '0;
        if (unit_hit) begin
            case (word)
                WRD_CNT: rd_next = 32'(psc_val);
                WRD_RLD: rd_next = 32'(psc_rld);
                WRD_CTL: rd_next = CFG_WORD;
                default: rd_next = '0;
            endcase
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (slot == 4'(i + 1)) begin
                    case (word)
                        WRD_CNT: rd_next = 32'(ch_cnt[i]);
                        WRD_RLD: rd_next = 32'(ch_rld[i]);
                        WRD_CTL: rd_next = ch_ctl[i];
                        default: rd_next = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int          NCH = 2,
    parameter int          CW  = 32,
    parameter int          PW  = 16,
    parameter logic [31:0] CFG = 32'h0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_en,
    input logic [7:0]             addr8,
    input logic [31:0]            rd_data,
    input logic                   psc_tick,
    input logic                   psc_wr_val,
    input logic [PW-1:0]          psc_val,
    input logic [PW-1:0]          psc_rld,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         ch_wr_cnt,
    input logic [NCH-1:0]         ch_wr_ctl,
    input logic [NCH-1:0][CW-1:0] ch_cnt,
    input logic [NCH-1:0][CW-1:0] ch_rld,
    input logic [NCH-1:0][31:0]   ch_ctl
);
    a_r5_cfg_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr8[7:2] == 6'h02) |=> (rd_data == CFG));

    a_r6_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr8[3:2] == 2'b11) |=> (rd_data == 32'h0));

    a_r3_psc_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr8[7:3] == 5'h00) |=> (rd_data[31:16] == 16'h0));

    a_r4_tick_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_tick && !psc_wr_val) |=> (psc_val == $past(psc_rld)));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r7_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> $past(ch_ctl[i][3]));

        a_r9_expire_halts: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctl[i][0] && !ch_ctl[i][1] && psc_tick && ch_cnt[i] == '0
             && !ch_wr_ctl[i] && !ch_wr_cnt[i]) |=> !ch_ctl[i][0]);

        a_r8_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctl[i][0] && ch_ctl[i][1] && psc_tick && ch_cnt[i] == '0
             && !ch_wr_ctl[i] && !ch_wr_cnt[i]) |=> (ch_cnt[i] == $past(ch_rld[i])));
    end
endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH), .CW(CW), .PW(PW), .CFG(CFG_WORD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .addr8      (addr),
    .rd_data    (rd_data),
    .psc_tick   (psc_tick),
    .psc_wr_val (psc_wr_val),
    .psc_val    (psc_val),
    .psc_rld    (psc_rld),
    .irq        (irq),
    .ch_wr_cnt  (ch_wr_cnt),
    .ch_wr_ctl  (ch_wr_ctl),
    .ch_cnt     (ch_cnt),
    .ch_rld     (ch_rld),
    .ch_ctl     (ch_ctl)
);

// File: tb/sim_tmr_unit.sv
`timescale 1ns/1ps
module sim_tmr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [1:0]  irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .irq     (irq)
    );

    // {is_write, addr, data, expected, requirement number}
    localparam int NV = 20;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 8'h08, 32'h0,        32'h342,      4'd5},  // R5 capability
        {1'b1, 8'h08, 32'hFFFFFFFF, 32'h0,        4'd5},
        {1'b0, 8'h08, 32'h0,        32'h342,      4'd5},  // R5 write ignored
        {1'b1, 8'h04, 32'h1234ABCD, 32'h0,        4'd3},
        {1'b0, 8'h04, 32'h0,        32'h0000ABCD, 4'd3},  // R3 mask
        {1'b1, 8'h14, 32'hDEADBEEF, 32'h0,        4'd2},
        {1'b0, 8'h14, 32'h0,        32'hDEADBEEF, 4'd2},  // R2 ch0 reload
        {1'b1, 8'h24, 32'h00000055, 32'h0,        4'd2},
        {1'b0, 8'h24, 32'h0,        32'h00000055, 4'd2},  // R2 ch1 reload
        {1'b0, 8'h34, 32'h0,        32'h0,        4'd6},  // R6 absent channel
        {1'b0, 8'h0C, 32'h0,        32'h0,        4'd6},  // R6 hole
        {1'b0, 8'h1C, 32'h0,        32'h0,        4'd6},
        {1'b0, 8'h2C, 32'h0,        32'h0,        4'd6},
        {1'b1, 8'h10, 32'h00000077, 32'h0,        4'd2},
        {1'b0, 8'h10, 32'h0,        32'h00000077, 4'd2},  // R2 ch0 counter
        {1'b1, 8'h18, 32'h0000000A, 32'h0,        4'd10},
        {1'b0, 8'h18, 32'h0,        32'h0000000A, 4'd10}, // R10 control
        {1'b1, 8'h18, 32'h0000000E, 32'h0,        4'd10},
        {1'b0, 8'h18, 32'h0,        32'h0000000A, 4'd10}, // R10 load reads 0
        {1'b0, 8'h10, 32'h0,        32'hDEADBEEF, 4'd10}  // R10 load copied
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        int hits;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", 32'(irq), 32'h0);
        bus_rd(8'h00, d); chk("R1 psc value", d, 32'h0);
        bus_rd(8'h04, d); chk("R1 psc reload", d, 32'h0);
        bus_rd(8'h10, d); chk("R1 ch0 counter", d, 32'h0);
        bus_rd(8'h14, d); chk("R1 ch0 reload", d, 32'h0);
        bus_rd(8'h18, d); chk("R1 ch0 control", d, 32'h0);
        bus_rd(8'h28, d); chk("R1 ch1 control", d, 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][76])
                bus_wr(VEC[v][75:68], VEC[v][67:36]);
            else begin
                bus_rd(VEC[v][75:68], d);
                chk($sformatf("R%0d table entry %0d", VEC[v][3:0], v), d, VEC[v][35:4]);
            end
        end

        // R8 periodic: prescaler reload 3, channel reload 2 -> 12 clocks
        bus_wr(8'h04, 32'd3);
        bus_wr(8'h00, 32'd0);
        bus_wr(8'h14, 32'd2);
        bus_wr(8'h18, 32'h0F);
        n = 0;
        while (!irq[0] && n < 200) begin @(negedge clk); n++; end
        chk("R8 first pulse seen", 32'(irq[0]), 32'h1);
        @(negedge clk);
        chk("R7 pulse one cycle wide", 32'(irq[0]), 32'h0);
        n = 1;
        while (!irq[0] && n < 200) begin @(negedge clk); n++; end
        chk("R8 period", 32'(n), 32'd12);

        // R10 pending behaviour
        bus_rd(8'h18, d); chk("R10 pending set, load reads 0", d, 32'h1B);
        bus_wr(8'h18, 32'h08);
        bus_rd(8'h18, d); chk("R10 bit4=0 keeps pending", d, 32'h18);
        bus_wr(8'h18, 32'h18);
        bus_rd(8'h18, d); chk("R10 bit4=1 clears pending", d, 32'h08);

        // R9 one-shot on ch1, tick every clock, counter 4
        bus_wr(8'h04, 32'd0);
        bus_wr(8'h00, 32'd0);
        bus_wr(8'h24, 32'd4);
        bus_wr(8'h28, 32'h0D);
        n = 0;
        while (!irq[1] && n < 200) begin @(negedge clk); n++; end
        chk("R7 underflow after counter+1 ticks", 32'(n), 32'd5);
        hits = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (irq[1]) hits++;
        end
        chk("R9 no further pulse", 32'(hits), 32'd0);
        bus_rd(8'h28, d); chk("R9 enable cleared", d, 32'h18);
        bus_rd(8'h20, d); chk("R9 counter stays 0", d, 32'h0);

        // R3 / R4 prescaler value write and countdown
        bus_wr(8'h04, 32'd3);
        bus_wr(8'h00, 32'h00010005);
        bus_rd(8'h00, d); chk("R4 psc value counts down (R3 masked)", d, 32'd4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule